// File: doc/BRIEF.md
# Single-Line External Interrupt Controller

This block watches one asynchronous interrupt pin, such as the wake or alarm line of a power-management device. It converts activity on that pin into a sticky pending flag, and it passes the flag upward as a registered interrupt request once software has enabled it. The pin is first brought into the clock domain. A detector then applies one of four trigger rules: active-low level, falling edge, active-high level or rising edge.

Software uses a plain single-cycle register port with three 32-bit registers. The control register holds the trigger rule. The pending register shows the latched event, and software clears it by writing a one. The enable register gates the interrupt request. A parameter selects the offsets of these registers from one of two maps, so the same block fits either address layout. The usual driver flow is as follows: disable, acknowledge any stale event, program the trigger rule with a read-modify-write, then enable. Later, software acknowledges after each serviced interrupt.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the trigger field reads 0 (active-low level), and the enable bit, the pending bit and `irq_o` are all 0.
- R2: With `ALT_MAP`=0 the registers are at byte offsets control 0x00, pending 0x04 and enable 0x08. A read from any other offset returns zero.
- R3: Control bits [1:0] hold the trigger code. A write stores only those two bits, and bits [31:2] of every register always read as zero.
- R4: Trigger codes 0 and 2 are level modes. Code 0 sets pending while the synchronised pin is low, and code 2 sets it while the pin is high. While the pin is at its inactive level, nothing is set.
- R5: Trigger codes 1 and 3 are edge modes. Code 1 sets pending on a high-to-low transition of the synchronised pin, and code 3 on a low-to-high transition. The opposite transition and a steady pin have no effect.
- R6: `irq_o` is a register that takes the value (pending bit 0 AND enable bit 0) one cycle later. With enable at 0, `irq_o` stays low whatever the pending state.
- R7: Writing 1 to pending bit 0 clears it, unless a new event occurs in the same cycle. Writing 0 leaves it unchanged.
- R8: In a level mode the pending bit is set again on every cycle that the pin stays active, so a clear does not last while the pin is still active.
- R9: In an edge mode, a qualifying edge in the same cycle as a clearing write wins, and the pending bit remains set.
- R10: A pin change made before clock edge k is seen by the detector after two synchroniser stages. The pending bit is set at edge k+2, and `irq_o` rises at edge k+3 when enabled.
- R11: With `ALT_MAP`=1 the registers are at control 0x0C, pending 0x10 and enable 0x40, and offset 0x00 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Raw asynchronous interrupt pin |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, zero when not reading |
| irq_o | output | 1 | Registered interrupt request to the upstream controller |

## Verification
The checker tests the following on every cycle: that the request tracks pending AND enable one cycle later, that a level-mode active pin always leaves the pending bit set, that the pending bit only falls through a clearing write, that an edge-mode event beats a clear, and that reset leaves everything idle. The bench alone can show the address decode of both maps, including zero reads at unmapped offsets. It also covers the masking of upper control bits, the two-stage pin latency counted in edges, and the sweep of all four trigger codes through their active, inactive and opposite-edge patterns.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
   typedef enum logic [1:0] {
      TRIG_LVL_LO   = 2'd0,
      TRIG_EDGE_FALL = 2'd1,
      TRIG_LVL_HI   = 2'd2,
      TRIG_EDGE_RISE = 2'd3
   } trig_e;

   localparam int TRIG_W = 2;

   // offsets of the two register maps
   localparam int MAP0_CTRL = 'h00;
   localparam int MAP0_PEND = 'h04;
   localparam int MAP0_EN   = 'h08;
   localparam int MAP1_CTRL = 'h0C;
   localparam int MAP1_PEND = 'h10;
   localparam int MAP1_EN   = 'h40;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/extirq_detect.sv
module extirq_detect
   import extirq_pkg::*;
#(
   parameter logic RST_VAL = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  trig_e mode,
   input  logic  lvl,
   output logic  prev,
   output logic  evt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= lvl;
   end

   always_comb begin
      unique case (mode)
         TRIG_LVL_LO:    evt = ~lvl;
         TRIG_EDGE_FALL: evt = prev & ~lvl;
         TRIG_LVL_HI:    evt = lvl;
         TRIG_EDGE_RISE: evt = ~prev & lvl;
         default:        evt = 1'b0;
      endcase
   end
endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
   import extirq_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter bit ALT_MAP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              evt,
   output trig_e             mode,
   output logic              pend,
   output logic              en,
   output logic              clr_hit
);
   localparam int PAD_W = DATA_W - TRIG_W;

   logic [ADDR_W-1:0] off_ctrl, off_pend, off_en;

   if (ALT_MAP) begin : g_map_alt
      assign off_ctrl = ADDR_W'(MAP1_CTRL);
      assign off_pend = ADDR_W'(MAP1_PEND);
      assign off_en   = ADDR_W'(MAP1_EN);
   end else begin : g_map_base
      assign off_ctrl = ADDR_W'(MAP0_CTRL);
      assign off_pend = ADDR_W'(MAP0_PEND);
      assign off_en   = ADDR_W'(MAP0_EN);
   end

   logic hit_ctrl, hit_pend, hit_en, wr, rd;
   assign hit_ctrl = (bus_addr == off_ctrl);
   assign hit_pend = (bus_addr == off_pend);
   assign hit_en   = (bus_addr == off_en);
   assign wr       = bus_sel &  bus_we;
   assign rd       = bus_sel & ~bus_we;
   assign clr_hit  = wr & hit_pend & bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= TRIG_LVL_LO;
         en   <= 1'b0;
      end else begin
         if (wr && hit_ctrl) mode <= trig_e'(bus_wdata[TRIG_W-1:0]);
         if (wr && hit_en)   en   <= bus_wdata[0];
      end
   end

   // a new event outranks a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= evt | (pend & ~clr_hit);
   end

   always_comb begin
      bus_rdata = '0;
      if (rd) begin
         if (hit_ctrl)      bus_rdata = {{PAD_W{1'b0}}, mode};
         else if (hit_pend) bus_rdata = {{(DATA_W-1){1'b0}}, pend};
         else if (hit_en)   bus_rdata = {{(DATA_W-1){1'b0}}, en};
      end
   end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
   import extirq_pkg::*;
#(
   parameter int   ADDR_W      = 8,
   parameter int   DATA_W      = 32,
   parameter bit   ALT_MAP     = 1'b0,
   parameter int   SYNC_STAGES = 2,
   parameter logic PIN_IDLE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_in,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);
   localparam int MAX_OFF = ALT_MAP ? MAP1_EN : MAP0_EN;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ext_irq_ctrl: SYNC_STAGES must be at least 2");
   end
   if ((1 << ADDR_W) <= MAX_OFF) begin : g_bad_addr
      $error("ext_irq_ctrl: ADDR_W too narrow for the selected map");
   end
   if (DATA_W < TRIG_W) begin : g_bad_data
      $error("ext_irq_ctrl: DATA_W narrower than the trigger field");
   end

   logic  lvl_s, lvl_prev, evt, pend_q, en_q, clr_hit, irq_q;
   trig_e mode_q;

   extirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_in),
      .dout (lvl_s)
   );

   extirq_detect #(.RST_VAL(PIN_IDLE)) u_det (
      .clk  (clk),
      .rst_n(rst_n),
      .mode (mode_q),
      .lvl  (lvl_s),
      .prev (lvl_prev),
      .evt  (evt)
   );

   extirq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALT_MAP(ALT_MAP)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_sel  (bus_sel),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .evt      (evt),
      .mode     (mode_q),
      .pend     (pend_q),
      .en       (en_q),
      .clr_hit  (clr_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= pend_q & en_q;
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/extirq_checker.sv
module extirq_checker
   import extirq_pkg::*;
(
   input logic  clk,
   input logic  rst_n,
   input trig_e mode,
   input logic  lvl,
   input logic  prev,
   input logic  pend,
   input logic  en,
   input logic  clr,
   input logic  irq
);
   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (!pend && !en && !irq && mode == TRIG_LVL_LO));

   assert_irq_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && en) |=> irq);

   assert_irq_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(pend && en) |=> !irq);

   assert_pend_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !clr) |=> pend);

   assert_level_resets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == TRIG_LVL_LO && !lvl) || (mode == TRIG_LVL_HI && lvl)) |=> pend);

   assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == TRIG_EDGE_RISE && lvl && !prev) ||
       (mode == TRIG_EDGE_FALL && !lvl && prev)) |=> pend);

   assert_no_false_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TRIG_EDGE_RISE && !pend && !(lvl && !prev)) |=> !pend);
endmodule

bind ext_irq_ctrl extirq_checker u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .mode (mode_q),
   .lvl  (lvl_s),
   .prev (lvl_prev),
   .pend (pend_q),
   .en   (en_q),
   .clr  (clr_hit),
   .irq  (irq_o)
);

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pin_in = 1'b1;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata_a, rdata_b;
   logic        irq_a, irq_b;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   ext_irq_ctrl u_ext_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .irq_o(irq_a));

   ext_irq_ctrl #(.ALT_MAP(1'b1)) u_alt (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .irq_o(irq_b));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(bit alt, logic [7:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1;
      d = alt ? rdata_b : rdata_a;
      bus_sel = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; failures++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      tick(3);
      rst_n = 1'b1;
      tick(2);

      // R1 reset state
      rd(0, 8'h00, v); check("R1 ctrl", v, 0);
      rd(0, 8'h04, v); check("R1 pend", v, 0);
      rd(0, 8'h08, v); check("R1 en", v, 0);
      check("R1 irq", irq_a, 0);

      // R2 unmapped offsets read zero
      wr(8'h08, 32'h1);
      rd(0, 8'h08, v); check("R2 en at 0x08", v, 1);
      rd(0, 8'h0C, v); check("R2 unmapped 0x0C", v, 0);
      rd(0, 8'h40, v); check("R2 unmapped 0x40", v, 0);
      wr(8'h08, 32'h0);

      // R3 only the trigger field is stored
      wr(8'h00, 32'hFFFF_FFFE);
      rd(0, 8'h00, v); check("R3 ctrl masked", v, 2);
      wr(8'h00, 32'h0);

      // sweep all trigger codes, R4 R5 R7 R8
      for (int m = 0; m < 4; m++) begin
         logic act_lvl;
         bit   is_edge;
         act_lvl = m[1];
         is_edge = m[0];
         pin_in = ~act_lvl;
         wr(8'h00, 32'(m));
         tick(4);
         wr(8'h04, 32'h1);
         tick(1);
         rd(0, 8'h04, v);
         check(is_edge ? "R5 idle pin" : "R4 inactive level", v, 0);
         pin_in = act_lvl;
         tick(4);
         rd(0, 8'h04, v);
         check(is_edge ? "R5 active edge" : "R4 active level", v, 1);
         check("R6 irq gated off", irq_a, 0);
         wr(8'h04, 32'h0);
         rd(0, 8'h04, v); check("R7 write 0 keeps", v, 1);
         wr(8'h04, 32'h1);
         rd(0, 8'h04, v);
         check(is_edge ? "R7 clear edge" : "R8 level re-sets", v, is_edge ? 1'b0 : 1'b1);
         pin_in = ~act_lvl;
         tick(4);
         if (is_edge) begin
            rd(0, 8'h04, v); check("R5 opposite edge", v, 0);
         end else begin
            wr(8'h04, 32'h1);
            rd(0, 8'h04, v); check("R7 clear after release", v, 0);
         end
      end

      // R10 latency and R6 enable gating in rising-edge mode
      wr(8'h00, 32'h3);
      pin_in = 1'b0;
      tick(4);
      wr(8'h04, 32'h1);
      wr(8'h08, 32'h1);
      tick(1);
      pin_in = 1'b1;
      tick(2);
      rd(0, 8'h04, v); check("R10 pend not yet", v, 0);
      tick(1);
      rd(0, 8'h04, v); check("R10 pend at k+2", v, 1);
      check("R10 irq not yet", irq_a, 0);
      tick(1);
      check("R10 irq at k+3", irq_a, 1);
      wr(8'h08, 32'h0);
      tick(1);
      check("R6 irq drops with enable", irq_a, 0);
      wr(8'h04, 32'h1);

      // R9 edge coincides with clear
      pin_in = 1'b0;
      tick(4);
      wr(8'h04, 32'h1);
      tick(1);
      pin_in = 1'b1;
      tick(2);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h1;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
      rd(0, 8'h04, v); check("R9 edge beats clear", v, 1);

      // R11 alternate map
      wr(8'h0C, 32'h2);
      rd(1, 8'h0C, v); check("R11 ctrl at 0x0C", v, 2);
      wr(8'h40, 32'h1);
      rd(1, 8'h40, v); check("R11 en at 0x40", v, 1);
      rd(1, 8'h10, v); check("R11 pend at 0x10", v, 1);
      rd(1, 8'h00, v); check("R11 0x00 unmapped", v, 0);
      tick(1);
      check("R11 alt irq", irq_b, 1);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule